// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block forms the signed product of two two's-complement words. Both words come in one after the other on a single data input. A single adder/subtractor of operand width and a one-place right shift do all the work. A free-running step counter sequences everything: its two low bits pick one of four substeps, and its upper bits pick the step. Step 0 loads the operands and clears the accumulator. Each of the next W-1 steps samples one multiplier bit, adds the multiplicand to the upper half when that bit is set, and shifts the upper and lower halves right together. Step W handles the multiplier's sign bit by subtracting the multiplicand. Step W+1 freezes the datapath and raises `done`.

The operand input is a valid/ready stream. `in_ready` is high only in the two load substeps of step 0. A word is taken on a rising edge where `in_valid` and `in_ready` are both high. The first word taken is the multiplicand and the second is the multiplier. While `in_ready` is high and `in_valid` is low, the counter holds. A source may therefore stall for any number of cycles without changing the result or the timing of later steps. `in_valid` has no effect in any cycle where `in_ready` is low. `start` and `done` are plain control pins. With the default W = 16, one multiplication takes 68 unstalled cycles.

Two one-bit registers change on the falling clock edge: a sign-fill flag and a shifted-out bit. Every other register changes on the rising edge. This lets a sample or an add-and-flag substep finish inside the same clock as its register write.

Top module: `seq_signed_mult`

## Requirements
- R1: While `done` is high, `product` (2W bits) equals the signed product multiplicand × multiplier, where the upper W bits are the accumulator and the lower W bits are the lower register. This holds for every combination of operand signs.
- R2: `in_ready` is high only at counter values 0 and 3. The word taken at counter value 0 is the multiplicand, and the word taken at counter value 3 is the multiplier. After a word is taken, `in_ready` is low on the next cycle.
- R3: While `in_ready` is high and `in_valid` is low, the counter does not advance and `in_ready` stays high. Stalls of any length leave the product unchanged.
- R4: With no stall at the multiplier load, `done` is first seen high 4·(W+1) rising edges after the edge that takes the multiplicand, counting that edge. Each stall cycle at the multiplier load adds exactly one edge.
- R5: Once `done` is high, it stays high and `product` stays stable until `start` is sampled high. A `start` pulse given while a multiplication is running has no effect on its result or latency.
- R6: A synchronous reset clears the counter, accumulator, lower register and both flags. After reset `done` is 0, `product` is 0 and `in_ready` is 1.
- R7: `start` sampled high while `done` is high returns the counter to 0. On the next cycle `in_ready` is 1 and `done` is 0.
- R8: The correction step fills the vacated top bit with the true sign of the (W+1)-bit difference. As a result, the most negative value squared gives +2^(2W-2).
- R9: Words offered with `in_valid` high while `in_ready` is low are not loaded and do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; counter and data registers use the rising edge, flags use the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Restarts the sequence when sampled high while `done` is high |
| in_valid | input | 1 | Operand word on `in_data` is valid |
| in_ready | output | 1 | Block is at a load substep and will take a word |
| in_data | input | W | Operand word: multiplicand first, then multiplier |
| done | output | 1 | Sequence has reached the stop step; `product` is valid |
| product | output | 2W | Signed product {accumulator, lower register} |

## Verification
All 1024 operand pairs in the range −16..15 are swept first. After that, a grid of edge values (0, ±1, the extremes, alternating-bit words, a value just above the most negative) is crossed with itself, with varied stalls on both loads, stray `in_valid` words between loads, and a `start` pulse in mid-run. Several faults show up here. If the sign flag did not stick, products with a negative multiplicand would come out wrong once a later add happened. If the correction step were missing or added instead of subtracting, every negative multiplier would give a wrong result. If the correction shift copied the top bit instead of the true sign, only the most negative value squared would fail, and it would come out negative. If stall handling were wrong, the latency would move or the wrong word would be loaded. If `start` were honoured while busy, the latency check would catch it.

// File: rtl/mult_pkg.sv
package mult_pkg;

  // Datapath operation selected for the current substep
  typedef enum logic [3:0] {
    OP_IDLE,
    OP_LD_MC,
    OP_CLR_HI,
    OP_CLR_FL,
    OP_LD_LO,
    OP_SAMPLE,
    OP_ADD,
    OP_SUB,
    OP_SHIFT_HI,
    OP_SHIFT_LO
  } op_e;

endpackage

// File: rtl/mult_addsub.sv
module mult_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         sgn
);

  logic [W:0] a_x;
  logic [W:0] b_x;
  logic [W:0] sum_x;

  // Sign-extend to W+1 bits so that the true sign of the result is kept
  assign a_x   = {a[W-1], a};
  assign b_x   = {b[W-1], b};
  assign sum_x = sub ? (a_x - b_x) : (a_x + b_x);
  assign res   = sum_x[W-1:0];
  assign sgn   = sum_x[W];

endmodule

// File: rtl/mult_seq.sv
module mult_seq
  import mult_pkg::*;
#(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic in_valid,
  output logic in_ready,
  output logic done,
  output op_e  op
);

  localparam int STOP = 4 * (W + 1);
  localparam int CW   = $clog2(STOP + 1);
  localparam logic [CW-1:0] STOP_CNT = CW'(STOP);

  logic [CW-1:0] cnt;
  logic [CW-3:0] step;
  logic [1:0]    sub;
  logic          advance;

  assign step     = cnt[CW-1:2];
  assign sub      = cnt[1:0];
  assign done     = (cnt == STOP_CNT);
  assign in_ready = (step == '0) && ((sub == 2'd0) || (sub == 2'd3));
  assign advance  = !done && !(in_ready && !in_valid);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (done && start) begin
      cnt <= '0;
    end else if (advance) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    op = OP_IDLE;
    if (step == '0) begin
      case (sub)
        2'd0:    op = OP_LD_MC;
        2'd1:    op = OP_CLR_HI;
        2'd2:    op = OP_CLR_FL;
        default: op = OP_LD_LO;
      endcase
    end else if (int'(step) <= W) begin
      case (sub)
        2'd0:    op = OP_SAMPLE;
        2'd1:    op = (int'(step) == W) ? OP_SUB : OP_ADD;
        2'd2:    op = OP_SHIFT_HI;
        default: op = OP_SHIFT_LO;
      endcase
    end
  end

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R3
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> (in_ready && $stable(cnt)));

  // R2
  take_once_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid) |=> !in_ready);

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= STOP_CNT);

endmodule

// File: rtl/mult_flags.sv
module mult_flags
  import mult_pkg::*;
#(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst,
  input  op_e  op,
  input  logic lo_lsb,
  input  logic hi_lsb,
  input  logic hi_msb,
  input  logic mc_msb,
  input  logic diff_sgn,
  output logic fill,
  output logic sout
);

  // Both flags change on the falling edge, in the middle of each substep
  always_ff @(negedge clk) begin
    if (rst) begin
      fill <= 1'b0;
      sout <= 1'b0;
    end else begin
      case (op)
        OP_CLR_FL: begin
          fill <= 1'b0;
          sout <= 1'b0;
        end
        OP_SAMPLE:   sout <= lo_lsb;
        OP_ADD:      fill <= fill | (mc_msb & sout);
        OP_SUB:      fill <= sout ? diff_sgn : hi_msb;
        OP_SHIFT_HI: sout <= hi_lsb;
        default: ;
      endcase
    end
  end

  // R1
  fill_sticky_chk: assert property (@(negedge clk) disable iff (rst)
    (op == OP_ADD && fill) |=> fill);

endmodule

// File: rtl/seq_signed_mult.sv
module seq_signed_mult
  import mult_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_data,
  output logic           done,
  output logic [2*W-1:0] product
);

  op_e          op;
  logic [W-1:0] mc_q;
  logic [W-1:0] hi_q;
  logic [W-1:0] lo_q;
  logic [W-1:0] alu_res;
  logic         alu_sgn;
  logic         fill;
  logic         sout;
  logic         take;

  mult_seq #(.W(W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .done     (done),
    .op       (op)
  );

  mult_addsub #(.W(W)) u_alu (
    .a   (hi_q),
    .b   (mc_q),
    .sub (op == OP_SUB),
    .res (alu_res),
    .sgn (alu_sgn)
  );

  mult_flags #(.W(W)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .lo_lsb   (lo_q[0]),
    .hi_lsb   (hi_q[0]),
    .hi_msb   (hi_q[W-1]),
    .mc_msb   (mc_q[W-1]),
    .diff_sgn (alu_sgn),
    .fill     (fill),
    .sout     (sout)
  );

  assign take = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      mc_q <= '0;
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      case (op)
        OP_LD_MC:    if (take) mc_q <= in_data;
        OP_CLR_HI:   hi_q <= '0;
        OP_LD_LO:    if (take) lo_q <= in_data;
        OP_ADD,
        OP_SUB:      if (sout) hi_q <= alu_res;
        OP_SHIFT_HI: hi_q <= {fill, hi_q[W-1:1]};
        OP_SHIFT_LO: lo_q <= {sout, lo_q[W-1:1]};
        default: ;
      endcase
    end
  end

  assign product = {hi_q, lo_q};

  // R5
  product_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> $stable(product));

  // R9
  no_stray_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && op != OP_SHIFT_LO) |=> $stable(lo_q));

endmodule

// File: tb/sim_seq_signed_mult.sv
module sim_seq_signed_mult;

  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [W-1:0]   in_data = '0;
  logic           done;
  logic [2*W-1:0] product;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;

  seq_signed_mult #(.W(W)) u0 (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .done     (done),
    .product  (product)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One multiplication; entered and left at a falling edge with the counter at 0
  task automatic run_mul(input logic signed [W-1:0] a, input logic signed [W-1:0] b,
                         input int st0, input int st1, input bit poke,
                         input bit hold, input string req);
    logic signed [2*W-1:0] exp;
    int edges;
    exp = a * b;
    in_valid = 1'b0;
    for (int i = 0; i < st0; i++) tick();
    if (st0 > 0) check(in_ready === 1'b1, "R3", longint'(in_ready), 1);
    in_data  = a;
    in_valid = 1'b1;
    tick();
    edges = 1;
    // R2: not ready right after a word is taken
    check(in_ready === 1'b0, "R2", longint'(in_ready), 0);
    // R9: stray words while not ready
    in_data = ~a;
    while (!in_ready && edges < 200) begin
      tick();
      edges++;
    end
    in_valid = 1'b0;
    for (int i = 0; i < st1; i++) begin
      tick();
      edges++;
    end
    in_data  = b;
    in_valid = 1'b1;
    tick();
    edges++;
    in_data = b ^ 16'hA5C3;
    while (!done && edges < 400) begin
      start = (poke && edges == 20);
      tick();
      edges++;
    end
    start = 1'b0;
    // R4 latency, also R5 when a busy start pulse was given
    check(edges == 4 * (W + 1) + st1, poke ? "R5" : "R4", edges, 4 * (W + 1) + st1);
    check(product === exp, req, product, exp);
    if (hold) begin
      for (int i = 0; i < 3; i++) tick();
      check(done === 1'b1 && product === exp, "R5", product, exp);
    end
    start = 1'b1;
    tick();
    start    = 1'b0;
    in_valid = 1'b0;
    check(in_ready === 1'b1 && done === 1'b0, "R7", {in_ready, done}, 2'b10);
  endtask

  function automatic logic signed [W-1:0] corner(input int k);
    case (k)
      0:       return 16'sd0;
      1:       return 16'sd1;
      2:       return -16'sd1;
      3:       return 16'sd2;
      4:       return -16'sd2;
      5:       return 16'h7FFF;
      6:       return 16'h8000;
      7:       return 16'h7FFE;
      8:       return 16'h8001;
      9:       return 16'h5555;
      10:      return 16'hAAAA;
      default: return 16'h00FF;
    endcase
  endfunction

  initial begin
    repeat (3) tick();
    // R6 reset state
    check(done === 1'b0 && product === '0 && in_ready === 1'b1, "R6", product, 0);
    rst = 1'b0;
    tick();

    // R8 most negative squared
    run_mul(16'h8000, 16'h8000, 0, 0, 1'b0, 1'b1, "R8");

    // R6 reset in the middle of a run
    in_data  = 16'd7;
    in_valid = 1'b1;
    for (int i = 0; i < 30; i++) tick();
    in_valid = 1'b0;
    rst = 1'b1;
    tick();
    tick();
    check(done === 1'b0 && product === '0 && in_ready === 1'b1, "R6", product, 0);
    rst = 1'b0;
    tick();

    // R1 all small operand pairs, all sign combinations
    for (int x = -16; x < 16; x++) begin
      for (int y = -16; y < 16; y++) begin
        run_mul(W'(x), W'(y), 0, 0, 1'b0, 1'b0, "R1");
      end
    end

    // R1 R3 edge values with stalls, busy start pulses and holds
    for (int i = 0; i < 12; i++) begin
      for (int j = 0; j < 12; j++) begin
        run_mul(corner(i), corner(j), i % 3, j % 2, ((i + j) % 5) == 0, i == j, "R1");
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule